// File: doc/BRIEF.md
# Octet-Synchronous PPP Framer

This block frames and deframes byte streams for PPP carried over an octet-synchronous link. On the transmit side, payload bytes arrive on a valid/ready handshake with a last-byte marker. The framer sends an opening flag, then the payload and then a frame check sequence. It finishes the frame with a closing flag. Any byte that the configuration marks as special is replaced by an escape byte followed by a modified copy. The line side gives one byte per cycle whenever its valid strobe is high.

On the receive side the block takes line bytes with a valid strobe and waits for a flag before it accepts anything. It removes escapes and drops unescaped control characters that the map marks. It withholds the trailing check bytes and delivers only the payload. When the closing flag arrives it pulses a frame-end strobe, together with an error bit for a bad or short frame. A separate strobe reports a frame that was aborted by an escape directly before a flag. Both directions use the same control-character map, the same four extra characters and the same check-sequence width selection.

Top module: `ppp_octet_framer`

## Requirements
- R1: After reset, `tx_valid_o`, `in_ready_o`, `rx_data_valid_o`, `rx_end_o`, `rx_err_o` and `rx_abort_o` are all low.
- R2: A transmitted frame is the flag 0x7E, then the payload, then the check sequence, then a second 0x7E, with one line byte per cycle.
- R3: The payload bytes 0x7E and 0x7D are always sent as 0x7D followed by the byte XOR 0x20.
- R4: A byte v below 0x20 is escaped when bit v of `accm_i` is 1 and is sent unchanged when that bit is 0.
- R5: Slot k of `xchar_i` (bits 8k+7..8k) is escaped when bit k of `xchar_en_i` is 1. A disabled slot has no effect.
- R6: With `crc32_sel_i`=0 the check sequence is a 16-bit CRC (reflected polynomial 0x1021, initial value 0xFFFF, complemented). It is computed over the unescaped payload and sent low byte first. Its bytes are escaped by the same rules as payload bytes.
- R7: With `crc32_sel_i`=1 the check sequence is a 32-bit CRC (reflected polynomial 0x04C11DB7, initial value 0xFFFFFFFF, complemented), sent as four bytes, least significant first.
- R8: The receiver delivers the unescaped payload without the check bytes. At the closing flag it pulses `rx_end_o` for one cycle with `rx_err_o` low when the check sequence is correct, and no data byte appears in that cycle.
- R9: A received frame whose check sequence is wrong ends with `rx_end_o` and `rx_err_o` both high.
- R10: A 0x7D followed directly by 0x7E pulses `rx_abort_o` and produces no `rx_end_o` for that frame. The flag then opens the next frame, which is received normally.
- R11: On receive, an unescaped byte below 0x20 whose `accm_i` bit is set is discarded. It is neither delivered nor included in the check.
- R12: A received frame that holds no more bytes than the check sequence ends with `rx_err_o` high. Two flags back to back produce no event.
- R13: While the second byte of an escape pair is being sent, `in_ready_o` is low. Once the opening flag has been sent, a payload supplied every cycle leaves no gap in the line bytes up to the closing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crc32_sel_i | input | 1 | 1 selects the 32-bit check sequence, 0 selects the 16-bit one |
| accm_i | input | 32 | Control-character escape map, bit v for byte value v |
| xchar_i | input | 32 | Four extra escape characters, slot k in bits 8k+7..8k |
| xchar_en_i | input | 4 | Enable for each extra character slot |
| in_valid_i | input | 1 | Transmit payload byte valid |
| in_data_i | input | 8 | Transmit payload byte |
| in_last_i | input | 1 | Marks the final payload byte of a frame |
| in_ready_o | output | 1 | Payload byte accepted on this cycle when valid |
| tx_byte_o | output | 8 | Line byte out |
| tx_valid_o | output | 1 | Line byte valid |
| rx_byte_i | input | 8 | Line byte in |
| rx_valid_i | input | 1 | Line byte in valid |
| rx_data_o | output | 8 | Received payload byte |
| rx_data_valid_o | output | 1 | Received payload byte valid |
| rx_end_o | output | 1 | Frame end strobe |
| rx_err_o | output | 1 | Check or length error, valid with `rx_end_o` |
| rx_abort_o | output | 1 | Aborted frame strobe |

## Verification
The hardest receive cases to reach from the ports are an escape that arrives right before a flag and a mapped control byte that is dropped in the middle of a frame. In both cases the check sequence has to be correct apart from the injected fault. The bench therefore builds each line stream from its own CRC model and replays it into the receiver, inserting or removing the one faulty byte at a chosen place. Escaping of the check-sequence bytes is covered by comparing whole transmitted frames against that model under several map and extra-character settings.

// File: rtl/ppp_pkg.sv
package ppp_pkg;
  localparam logic [7:0]  FLAG   = 8'h7E;
  localparam logic [7:0]  ESC    = 8'h7D;
  localparam logic [7:0]  XMASK  = 8'h20;
  localparam logic [15:0] GOOD16 = 16'hF0B8;
  localparam logic [31:0] GOOD32 = 32'hDEBB20E3;
  localparam logic [31:0] POLY16 = 32'h0000_8408;
  localparam logic [31:0] POLY32 = 32'hEDB8_8320;

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_FCS, TX_CLOSE} tx_state_e;

  // one byte of reflected CRC, LSB first
  function automatic logic [31:0] fcs_step(input logic [31:0] c, input logic [7:0] d,
                                           input logic wide);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ (wide ? POLY32 : POLY16);
      else             r = r >> 1;
    end
    if (!wide) r[31:16] = '0;
    return r;
  endfunction
endpackage

// File: rtl/ppp_fcs.sv
module ppp_fcs
  import ppp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wide_i,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_o <= 32'hFFFF_FFFF;
    else if (clear_i) crc_o <= wide_i ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    else if (en_i)    crc_o <= fcs_step(crc_o, data_i, wide_i);
  end
endmodule

// File: rtl/ppp_esc_sel.sv
module ppp_esc_sel
  import ppp_pkg::*;
#(
  parameter int N_EXTRA = 4
) (
  input  logic [7:0]           byte_i,
  input  logic [31:0]          accm_i,
  input  logic [N_EXTRA*8-1:0] xchar_i,
  input  logic [N_EXTRA-1:0]   xchar_en_i,
  output logic                 esc_o
);
  logic [N_EXTRA-1:0] hit;
  logic               ctl;

  for (genvar g = 0; g < N_EXTRA; g++) begin : g_xc
    assign hit[g] = xchar_en_i[g] && (xchar_i[g*8 +: 8] == byte_i);
  end

  assign ctl   = (byte_i < 8'h20) && accm_i[byte_i[4:0]];
  assign esc_o = (byte_i == FLAG) || (byte_i == ESC) || ctl || (|hit);
endmodule

// File: rtl/ppp_tx.sv
module ppp_tx
  import ppp_pkg::*;
#(
  parameter int N_EXTRA = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wide_i,
  input  logic [31:0]          accm_i,
  input  logic [N_EXTRA*8-1:0] xchar_i,
  input  logic [N_EXTRA-1:0]   xchar_en_i,
  input  logic                 in_valid_i,
  input  logic [7:0]           in_data_i,
  input  logic                 in_last_i,
  output logic                 in_ready_o,
  output logic [7:0]           tx_byte_o,
  output logic                 tx_valid_o
);
  tx_state_e   st_q;
  logic        esc_pend_q, last_q;
  logic [7:0]  pend_q;
  logic [2:0]  left_q;
  logic [2:0]  nb;
  logic [1:0]  idx;
  logic [31:0] crc, fcs_word;
  logic [7:0]  fcs_byte, sel_byte;
  logic        need_esc, take;

  assign nb         = wide_i ? 3'd4 : 3'd2;
  assign fcs_word   = ~crc;
  assign idx        = 2'(nb - left_q);
  assign fcs_byte   = fcs_word[{idx, 3'b000} +: 8];
  assign in_ready_o = (st_q == TX_DATA) && !esc_pend_q;
  assign take       = in_valid_i && in_ready_o;
  assign sel_byte   = (st_q == TX_FCS) ? fcs_byte : in_data_i;

  ppp_esc_sel #(.N_EXTRA(N_EXTRA)) u_esc (
    .byte_i(sel_byte), .accm_i(accm_i), .xchar_i(xchar_i),
    .xchar_en_i(xchar_en_i), .esc_o(need_esc)
  );

  ppp_fcs u_fcs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i),
    .clear_i(st_q == TX_IDLE), .en_i(take), .data_i(in_data_i), .crc_o(crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= TX_IDLE;
      esc_pend_q <= 1'b0;
      last_q     <= 1'b0;
      pend_q     <= '0;
      left_q     <= '0;
      tx_byte_o  <= '0;
      tx_valid_o <= 1'b0;
    end else begin
      tx_valid_o <= 1'b0;
      unique case (st_q)
        TX_IDLE: if (in_valid_i) begin
          tx_byte_o  <= FLAG;
          tx_valid_o <= 1'b1;
          last_q     <= 1'b0;
          st_q       <= TX_DATA;
        end
        TX_DATA: begin
          if (esc_pend_q) begin
            tx_byte_o  <= pend_q ^ XMASK;
            tx_valid_o <= 1'b1;
            esc_pend_q <= 1'b0;
            if (last_q) begin
              st_q   <= TX_FCS;
              left_q <= nb;
            end
          end else if (take) begin
            tx_valid_o <= 1'b1;
            if (need_esc) begin
              tx_byte_o  <= ESC;
              pend_q     <= in_data_i;
              esc_pend_q <= 1'b1;
              last_q     <= in_last_i;
            end else begin
              tx_byte_o <= in_data_i;
              if (in_last_i) begin
                st_q   <= TX_FCS;
                left_q <= nb;
              end
            end
          end
        end
        TX_FCS: begin
          tx_valid_o <= 1'b1;
          if (esc_pend_q) begin
            tx_byte_o  <= pend_q ^ XMASK;
            esc_pend_q <= 1'b0;
            if (left_q == 3'd0) st_q <= TX_CLOSE;
          end else begin
            left_q <= left_q - 3'd1;
            if (need_esc) begin
              tx_byte_o  <= ESC;
              pend_q     <= fcs_byte;
              esc_pend_q <= 1'b1;
            end else begin
              tx_byte_o <= fcs_byte;
              if (left_q == 3'd1) st_q <= TX_CLOSE;
            end
          end
        end
        TX_CLOSE: begin
          tx_byte_o  <= FLAG;
          tx_valid_o <= 1'b1;
          st_q       <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  // R3: an escape byte is always followed by its partner in the next cycle
  a_r3_esc_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_byte_o == ESC) |=> tx_valid_o);
  // R13: an accepted payload byte reaches the line in the next cycle
  a_r13_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> tx_valid_o);
  // R2: the closing state emits a flag
  a_r2_close_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_CLOSE) |=> (tx_valid_o && tx_byte_o == FLAG));
endmodule

// File: rtl/ppp_rx.sv
module ppp_rx
  import ppp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wide_i,
  input  logic [31:0] accm_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_valid_i,
  output logic [7:0]  rx_data_o,
  output logic        rx_data_valid_o,
  output logic        rx_end_o,
  output logic        rx_err_o,
  output logic        rx_abort_o
);
  localparam int DEPTH = 4;

  logic                  in_frame_q, esc_q;
  logic [2:0]            cnt_q;
  logic [DEPTH-1:0][7:0] dly_q;
  logic                  is_flag, is_esc, mapped, store, crc_ok;
  logic [7:0]            st_byte, oldest;
  logic [31:0]           crc;
  logic [2:0]            nb;

  assign nb      = wide_i ? 3'd4 : 3'd2;
  assign is_flag = rx_valid_i && (rx_byte_i == FLAG);
  assign is_esc  = rx_byte_i == ESC;
  assign mapped  = (rx_byte_i < 8'h20) && accm_i[rx_byte_i[4:0]];
  assign store   = rx_valid_i && in_frame_q && !is_flag && !is_esc && (esc_q || !mapped);
  assign st_byte = esc_q ? (rx_byte_i ^ XMASK) : rx_byte_i;
  assign crc_ok  = wide_i ? (crc == GOOD32) : (crc[15:0] == GOOD16);
  assign oldest  = wide_i ? dly_q[3] : dly_q[1];

  ppp_fcs u_fcs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i),
    .clear_i(is_flag), .en_i(store), .data_i(st_byte), .crc_o(crc)
  );

  // holds back the trailing check bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dly_q <= '0;
    else if (store) dly_q <= {dly_q[DEPTH-2:0], st_byte};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q      <= 1'b0;
      esc_q           <= 1'b0;
      cnt_q           <= '0;
      rx_data_o       <= '0;
      rx_data_valid_o <= 1'b0;
      rx_end_o        <= 1'b0;
      rx_err_o        <= 1'b0;
      rx_abort_o      <= 1'b0;
    end else begin
      rx_data_valid_o <= 1'b0;
      rx_end_o        <= 1'b0;
      rx_err_o        <= 1'b0;
      rx_abort_o      <= 1'b0;
      if (is_flag) begin
        if (in_frame_q) begin
          if (esc_q) rx_abort_o <= 1'b1;
          else if (cnt_q != 3'd0) begin
            rx_end_o <= 1'b1;
            rx_err_o <= (cnt_q <= nb) || !crc_ok;
          end
        end
        in_frame_q <= 1'b1;
        esc_q      <= 1'b0;
        cnt_q      <= '0;
      end else if (rx_valid_i && in_frame_q) begin
        if (is_esc) esc_q <= 1'b1;
        else begin
          esc_q <= 1'b0;
          if (store) begin
            if (cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
            if (cnt_q >= nb) begin
              rx_data_o       <= oldest;
              rx_data_valid_o <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R8: end strobe lasts one cycle and carries no data byte
  a_r8_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_end_o |=> !rx_end_o);
  a_r8_no_data_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_end_o |-> !rx_data_valid_o);
  // R9: error only qualifies a frame end
  a_r9_err_with_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> rx_end_o);
  // R10: abort and end are exclusive
  a_r10_abort_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_end_o, rx_abort_o}));
endmodule

// File: rtl/ppp_octet_framer.sv
module ppp_octet_framer
  import ppp_pkg::*;
#(
  parameter int N_EXTRA = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 crc32_sel_i,
  input  logic [31:0]          accm_i,
  input  logic [N_EXTRA*8-1:0] xchar_i,
  input  logic [N_EXTRA-1:0]   xchar_en_i,
  input  logic                 in_valid_i,
  input  logic [7:0]           in_data_i,
  input  logic                 in_last_i,
  output logic                 in_ready_o,
  output logic [7:0]           tx_byte_o,
  output logic                 tx_valid_o,
  input  logic [7:0]           rx_byte_i,
  input  logic                 rx_valid_i,
  output logic [7:0]           rx_data_o,
  output logic                 rx_data_valid_o,
  output logic                 rx_end_o,
  output logic                 rx_err_o,
  output logic                 rx_abort_o
);
  ppp_tx #(.N_EXTRA(N_EXTRA)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(crc32_sel_i), .accm_i(accm_i),
    .xchar_i(xchar_i), .xchar_en_i(xchar_en_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .tx_byte_o(tx_byte_o), .tx_valid_o(tx_valid_o)
  );

  ppp_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(crc32_sel_i), .accm_i(accm_i),
    .rx_byte_i(rx_byte_i), .rx_valid_i(rx_valid_i),
    .rx_data_o(rx_data_o), .rx_data_valid_o(rx_data_valid_o),
    .rx_end_o(rx_end_o), .rx_err_o(rx_err_o), .rx_abort_o(rx_abort_o)
  );
endmodule

// File: tb/ppp_octet_framer_bench.sv
module ppp_octet_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crc32_sel = 1'b0;
  logic [31:0] accm = '0;
  logic [31:0] xchar = '0;
  logic [3:0]  xchar_en = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_data_valid, rx_end, rx_err, rx_abort;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] pl[64];  int pl_n;
  logic [7:0] ex[256]; int ex_n;
  logic [7:0] cap[256]; int cap_cyc[256]; int cap_n = 0;
  logic [7:0] rxd[256]; int rxd_n = 0;
  int end_n = 0, abort_n = 0; logic err_last = 1'b0;

  always #10 clk = ~clk;

  ppp_octet_framer u_ppp_octet_framer (
    .clk_i(clk), .rst_ni(rst_n), .crc32_sel_i(crc32_sel), .accm_i(accm),
    .xchar_i(xchar), .xchar_en_i(xchar_en),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready), .tx_byte_o(tx_byte), .tx_valid_o(tx_valid),
    .rx_byte_i(rx_byte), .rx_valid_i(rx_valid),
    .rx_data_o(rx_data), .rx_data_valid_o(rx_data_valid),
    .rx_end_o(rx_end), .rx_err_o(rx_err), .rx_abort_o(rx_abort)
  );

  always @(negedge clk) begin
    cyc++;
    if (tx_valid) begin cap[cap_n] = tx_byte; cap_cyc[cap_n] = cyc; cap_n++; end
    if (rx_data_valid) begin rxd[rxd_n] = rx_data; rxd_n++; end
    if (rx_end) begin end_n++; err_last = rx_err; end
    if (rx_abort) abort_n++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb = r[0] ^ d[b];
      r = r >> 1;
      if (fb) r = r ^ (crc32_sel ? 32'hEDB88320 : 32'h00008408);
    end
    return r;
  endfunction

  function automatic bit must_esc(input logic [7:0] b);
    bit e = (b == 8'h7E) || (b == 8'h7D) || ((b < 8'h20) && accm[b[4:0]]);
    for (int k = 0; k < 4; k++) if (xchar_en[k] && xchar[k*8 +: 8] == b) e = 1;
    return e;
  endfunction

  task automatic push_raw(input logic [7:0] b); ex[ex_n] = b; ex_n++; endtask
  task automatic push_esc(input logic [7:0] b);
    if (must_esc(b)) begin push_raw(8'h7D); push_raw(b ^ 8'h20); end
    else push_raw(b);
  endtask

  task automatic build_exp();
    logic [31:0] c = crc32_sel ? 32'hFFFFFFFF : 32'h0000FFFF;
    int nb = crc32_sel ? 4 : 2;
    ex_n = 0;
    push_raw(8'h7E);
    for (int i = 0; i < pl_n; i++) begin c = ref_crc(c, pl[i]); push_esc(pl[i]); end
    c = ~c;
    for (int k = 0; k < nb; k++) push_esc(c[8*k +: 8]);
    push_raw(8'h7E);
  endtask

  task automatic send_tx();
    cap_n = 0;
    for (int i = 0; i < pl_n; i++) begin
      bit hs = 0;
      in_valid = 1; in_data = pl[i]; in_last = (i == pl_n - 1);
      while (!hs) begin hs = in_ready; @(negedge clk); end
    end
    in_valid = 0; in_last = 0;
    repeat (16) @(negedge clk);
    build_exp();
  endtask

  task automatic cmp_tx(input string r);
    int mis = -1;
    chk(cap_n == ex_n, {r, " frame length"}, cap_n, ex_n);
    for (int i = 0; i < ex_n && i < cap_n; i++) if (mis < 0 && cap[i] != ex[i]) mis = i;
    if (mis >= 0) chk(0, {r, " frame byte"}, cap[mis], ex[mis]);
    else chk(1, r, 0, 0);
  endtask

  task automatic rx_put(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; @(negedge clk);
  endtask

  task automatic rx_clear();
    rxd_n = 0; end_n = 0; abort_n = 0; err_last = 0;
  endtask

  task automatic replay(input int ins_at, input logic [7:0] ins_b);
    for (int i = 0; i < ex_n; i++) begin
      if (i == ins_at) rx_put(ins_b);
      rx_put(ex[i]);
    end
    rx_valid = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_rx(input string r);
    int mis = -1;
    chk(rxd_n == pl_n, {r, " data count"}, rxd_n, pl_n);
    for (int i = 0; i < pl_n && i < rxd_n; i++) if (mis < 0 && rxd[i] != pl[i]) mis = i;
    if (mis >= 0) chk(0, {r, " data byte"}, rxd[mis], pl[mis]);
    else chk(1, r, 0, 0);
  endtask

  task automatic t_reset();
    chk(tx_valid == 0 && in_ready == 0, "R1 tx idle after reset", {tx_valid, in_ready}, 0);
    chk(rx_data_valid == 0 && rx_end == 0 && rx_err == 0 && rx_abort == 0,
        "R1 rx idle after reset", {rx_data_valid, rx_end, rx_err, rx_abort}, 0);
  endtask

  task automatic t_tx_basic();
    crc32_sel = 0; accm = 0; xchar_en = 0;
    pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h41; pl[3] = 8'hC3; pl_n = 4;
    send_tx();
    chk(cap[0] == 8'h7E && cap[cap_n-1] == 8'h7E, "R2 flags around frame", cap[0], 8'h7E);
    cmp_tx("R6 crc16 frame");
  endtask

  task automatic t_tx_flagesc();
    crc32_sel = 0; accm = 0; xchar_en = 0;
    pl[0] = 8'h7E; pl[1] = 8'h10; pl[2] = 8'h7D; pl[3] = 8'h5A; pl_n = 4;
    send_tx();
    chk(cap[1] == 8'h7D && cap[2] == 8'h5E, "R3 flag escaped", {cap[1], cap[2]}, 16'h7D5E);
    chk(cap[4] == 8'h7D && cap[5] == 8'h5D, "R3 escape escaped", {cap[4], cap[5]}, 16'h7D5D);
    cmp_tx("R3 frame");
    chk(cap_cyc[cap_n-1] - cap_cyc[0] == cap_n - 1, "R13 no line gap",
        cap_cyc[cap_n-1] - cap_cyc[0], cap_n - 1);
  endtask

  task automatic t_tx_accm();
    crc32_sel = 0; accm = 32'h0000_0008; xchar_en = 0;
    pl[0] = 8'h03; pl[1] = 8'h04; pl[2] = 8'h1F; pl_n = 3;
    send_tx();
    chk(cap[1] == 8'h7D && cap[2] == 8'h23, "R4 mapped byte escaped", {cap[1], cap[2]}, 16'h7D23);
    chk(cap[3] == 8'h04, "R4 unmapped byte plain", cap[3], 8'h04);
    cmp_tx("R4 frame");
  endtask

  task automatic t_tx_extra();
    crc32_sel = 0; accm = 0;
    xchar = {8'h00, 8'hAA, 8'h55, 8'h00}; xchar_en = 4'b0010;
    pl[0] = 8'h55; pl[1] = 8'hAA; pl_n = 2;
    send_tx();
    chk(cap[1] == 8'h7D && cap[2] == 8'h75, "R5 enabled slot escaped", {cap[1], cap[2]}, 16'h7D75);
    chk(cap[3] == 8'hAA, "R5 disabled slot ignored", cap[3], 8'hAA);
    cmp_tx("R5 frame");
    xchar_en = 0;
  endtask

  task automatic t_tx_crc32();
    crc32_sel = 1; accm = 0; xchar_en = 0;
    for (int i = 0; i < 5; i++) pl[i] = 8'h31 + 8'(i);
    pl_n = 5;
    send_tx();
    cmp_tx("R7 crc32 frame");
    crc32_sel = 0;
  endtask

  task automatic t_rx_good(input logic wide);
    crc32_sel = wide; accm = 32'hFFFF_FFFF; xchar_en = 0;
    pl[0] = 8'h11; pl[1] = 8'h7E; pl[2] = 8'h02; pl[3] = 8'h99; pl[4] = 8'h7D; pl_n = 5;
    build_exp(); rx_clear();
    replay(-1, 8'h00);
    cmp_rx(wide ? "R8 crc32 rx" : "R8 crc16 rx");
    chk(end_n == 1 && err_last == 0, "R8 end without error", {end_n[7:0], 7'b0, err_last}, 16'h0100);
    accm = 0; crc32_sel = 0;
  endtask

  task automatic t_rx_bad();
    crc32_sel = 0; accm = 0;
    pl[0] = 8'h40; pl[1] = 8'h41; pl[2] = 8'h42; pl_n = 3;
    build_exp(); ex[2] = ex[2] ^ 8'h01; rx_clear();
    replay(-1, 8'h00);
    chk(end_n == 1 && err_last == 1, "R9 bad check flagged", {end_n[7:0], 7'b0, err_last}, 16'h0101);
  endtask

  task automatic t_rx_abort();
    crc32_sel = 0; accm = 0; rx_clear();
    rx_put(8'h7E); rx_put(8'h11); rx_put(8'h22); rx_put(8'h7D);
    pl[0] = 8'h61; pl[1] = 8'h62; pl[2] = 8'h63; pl_n = 3;
    build_exp();
    replay(-1, 8'h00);  // opens with the flag that ends the aborted frame
    chk(abort_n == 1, "R10 abort strobe", abort_n, 1);
    chk(end_n == 1 && err_last == 0, "R10 next frame ok", {end_n[7:0], 7'b0, err_last}, 16'h0100);
    cmp_rx("R10 next frame data");
  endtask

  task automatic t_rx_drop();
    crc32_sel = 0; accm = 32'h0000_0020;
    pl[0] = 8'hA1; pl[1] = 8'hB2; pl_n = 2;
    build_exp(); rx_clear();
    replay(2, 8'h05);
    cmp_rx("R11 mapped byte dropped");
    chk(end_n == 1 && err_last == 0, "R11 check ignores dropped", {end_n[7:0], 7'b0, err_last}, 16'h0100);
    accm = 0;
  endtask

  task automatic t_rx_short();
    crc32_sel = 0; accm = 0; rx_clear();
    rx_put(8'h7E); rx_put(8'h12); rx_put(8'h7E);
    rx_valid = 0; repeat (3) @(negedge clk);
    chk(end_n == 1 && err_last == 1, "R12 short frame error", {end_n[7:0], 7'b0, err_last}, 16'h0101);
    chk(rxd_n == 0, "R12 short frame no data", rxd_n, 0);
    rx_put(8'h7E);
    rx_valid = 0; repeat (3) @(negedge clk);
    chk(end_n == 1 && abort_n == 0, "R12 empty frame silent", end_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_flagesc();
    t_tx_accm();
    t_tx_extra();
    t_tx_crc32();
    t_rx_good(1'b0);
    t_rx_good(1'b1);
    t_rx_bad();
    t_rx_abort();
    t_rx_drop();
    t_rx_short();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule